// File: doc/BRIEF.md
# SPI Flash Memory-Mapped Read Engine

This engine turns a single bus read into one complete serial flash read transaction. When a read request is accepted, it asserts the chip select. It then shifts out the command byte, the address, and any dummy bytes. Next it clocks in one, two or four data bytes. Finally it releases the chip select and returns the assembled data with a one-cycle valid pulse. The SPI signals are single-bit: one serial clock, one active-low select, one data-out line and one data-in line.

Every aspect of a transaction comes from a 32-bit per-select control word that is sampled when the request is accepted. The word selects the command mode, the opcode, a dummy-byte count whose bits are split across the word, and the bit order. It also sets the clock polarity and the serial clock rate, and the minimum deselect time. A separate per-select input chooses 3-byte or 4-byte addressing. A request is held off while a transaction is running; it is never dropped.

Top module: `spi_xip_reader`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, rsp_valid is 0, and req_ready is 1 while ctrl_word is 0.
- R2: The first byte of each transaction is the opcode taken from ctrl_word[23:16].
- R3: With wide_addr_en clear, three address bytes follow the opcode: req_offset[23:16], then [15:8], then [7:0], and bits 31:24 are not sent. With it set, four bytes from [31:24] down to [7:0] follow.
- R4: The command mode is ctrl_word[1:0] (0 normal read, 1 fast read, 2 write, 3 user). Only fast read inserts dummy bytes, with the count {ctrl_word[14], ctrl_word[7:6]} from 0 to 7. Modes 0 and 2 send no dummy bytes whatever those bits hold.
- R5: req_size 0, 1 and 2 (3 acts as 2) read 1, 2 and 4 data bytes. The first received byte lands in rsp_data[7:0], the next in [15:8], and so on, and unread bytes are 0. rsp_valid pulses for one cycle.
- R6: When ctrl_word[5] is 1, every byte is shifted least-significant bit first in both directions; otherwise most-significant bit first.
- R7: ctrl_word[4]=1 selects clock mode 3 (SCLK idles high) and 0 selects mode 0 (idles low). Data in is sampled on SCLK rising edges, and data out changes only while SCLK is low. SCLK makes no edge in the cycle spi_cs_n falls.
- R8: Each SCLK high and low phase lasts (ctrl_word[11:8]+1) clock cycles, multiplied by 4 when ctrl_word[13] is 1.
- R9: spi_cs_n stays low for the whole transaction and rises in the cycle rsp_valid pulses. It then stays high for at least 16 - ctrl_word[27:24] clock cycles.
- R10: req_ready is 0 while a transaction or its deselect time is in progress. A request held meanwhile is accepted afterwards and served with its own offset.
- R11: A request in user mode (3) is answered in the next cycle with rsp_valid and rsp_data 0, with no chip-select activity.
- R12: ctrl_word and wide_addr_en are sampled at acceptance. Changing them during a transaction does not alter that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 32 | Per-select control word |
| wide_addr_en | input | 1 | Selects 4-byte addressing for this select |
| req_valid | input | 1 | Read request present |
| req_offset | input | 32 | Byte offset within the flash |
| req_size | input | 2 | Size code: 0=1, 1=2, 2 or 3=4 bytes |
| req_ready | output | 1 | Request is accepted in this cycle when valid |
| rsp_valid | output | 1 | One-cycle pulse, read data ready |
| rsp_data | output | 32 | Read data, first byte in bits 7:0 |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Two things can fall in the same cycle: the completion of one transaction (response pulse and chip-select release) and the arrival of the next request, along with a change of the control word. The bench holds a second request valid with a different offset across a whole transaction. It checks that ready stays low, that the first response carries the first address, and that the second is served afterwards with its own header bytes. It also rewrites the control word and address width right after acceptance and checks that the running transaction still follows the values sampled at acceptance.

// File: rtl/spird_pkg.sv
package spird_pkg;

    localparam int HALF_W   = 7;   // up to (15+1)*4 = 64 cycles per phase
    localparam int GAP_W    = 5;   // deselect time 1..16
    localparam int IDX_W    = 5;   // byte index within a transaction
    localparam int MAX_DATA = 4;   // data bytes per read

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_FAST  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_USER  = 2'd3
    } cmd_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        cmd_mode_e          mode;
        logic [7:0]         opcode;
        logic [2:0]         dummy;
        logic               lsb_first;
        logic               cpol;
        logic [HALF_W-1:0]  half;
        logic [GAP_W-1:0]   gap;
    } xfer_cfg_t;

    function automatic xfer_cfg_t decode_ctrl(input logic [31:0] w);
        xfer_cfg_t         c;
        logic [HALF_W-1:0] base;
        base        = HALF_W'(w[11:8]) + HALF_W'(1);
        c.mode      = cmd_mode_e'(w[1:0]);
        c.opcode    = w[23:16];
        c.dummy     = {w[14], w[7:6]};
        c.lsb_first = w[5];
        c.cpol      = w[4];
        c.half      = w[13] ? (base << 2) : base;
        c.gap       = GAP_W'(16) - GAP_W'(w[27:24]);
        return c;
    endfunction

    function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/spird_shifter.sv
module spird_shifter
    import spird_pkg::*;
#(
    parameter int TW = HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [7:0]    tx_byte,
    input  logic          lsb_first,
    input  logic [TW-1:0] half,
    input  logic          cpol,
    input  logic          miso,
    output logic          done,
    output logic [7:0]    rx_byte,
    output logic          sclk,
    output logic          mosi
);

    logic          active;
    logic          phase_hi;
    logic [2:0]    bit_idx;
    logic [TW-1:0] timer;
    logic [7:0]    sh_tx;
    logic [7:0]    sh_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            phase_hi <= 1'b0;
            bit_idx  <= '0;
            timer    <= '0;
            sh_tx    <= '0;
            sh_rx    <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active   <= 1'b1;
                phase_hi <= 1'b0;
                timer    <= half - TW'(1);
                bit_idx  <= '0;
                sh_tx    <= tx_byte;
            end else if (active) begin
                if (timer != '0) begin
                    timer <= timer - TW'(1);
                end else if (!phase_hi) begin
                    phase_hi <= 1'b1;
                    timer    <= half - TW'(1);
                    sh_rx    <= lsb_first ? {miso, sh_rx[7:1]} : {sh_rx[6:0], miso};
                end else begin
                    phase_hi <= 1'b0;
                    timer    <= half - TW'(1);
                    if (bit_idx == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 3'd1;
                        sh_tx   <= lsb_first ? {1'b0, sh_tx[7:1]} : {sh_tx[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign rx_byte = sh_rx;
    assign mosi    = lsb_first ? sh_tx[0] : sh_tx[7];
    assign sclk    = active ? phase_hi : cpol;

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && phase_hi && $past(active && phase_hi)) |-> $stable(mosi)); // R7

endmodule

// File: rtl/spird_seq.sv
module spird_seq
    import spird_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       ctrl_word,
    input  logic              wide_addr_en,
    input  logic              req_valid,
    input  logic [31:0]       req_offset,
    input  logic [1:0]        req_size,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              cs_n,
    output logic              sh_start,
    output logic [7:0]        sh_tx,
    output logic              sh_lsb,
    output logic [HALF_W-1:0] sh_half,
    output logic              sh_cpol,
    input  logic              sh_done,
    input  logic [7:0]        sh_rx
);

    seq_state_e        state;
    xfer_cfg_t         cfg_in;
    logic [7:0]        op_q;
    logic              lsb_q;
    logic              cpol_q;
    logic [HALF_W-1:0] half_q;
    logic [GAP_W-1:0]  gap_q;
    logic [GAP_W-1:0]  gap_cnt;
    logic [31:0]       offs_q;
    logic [2:0]        alen_q;
    logic [IDX_W-1:0]  idx, base_q, last_q;
    logic [31:0]       rdata, rdata_nx;
    logic [2:0]        alen_in, dum_in, nb_in;
    logic [IDX_W-1:0]  didx, asel;

    assign cfg_in    = decode_ctrl(ctrl_word);
    assign alen_in   = wide_addr_en ? 3'd4 : 3'd3;
    assign dum_in    = (cfg_in.mode == CMD_FAST) ? cfg_in.dummy : 3'd0;
    assign nb_in     = size_to_bytes(req_size);
    assign req_ready = (state == ST_IDLE) && (cpol_q == cfg_in.cpol);

    assign sh_start  = (state == ST_LOAD);
    assign sh_lsb    = lsb_q;
    assign sh_half   = half_q;
    assign sh_cpol   = cpol_q;

    assign didx = idx - base_q;
    assign asel = IDX_W'(alen_q) - idx;

    always_comb begin
        if (idx == '0)
            sh_tx = op_q;
        else if (idx <= IDX_W'(alen_q))
            sh_tx = 8'(offs_q >> {asel[1:0], 3'b000});
        else
            sh_tx = 8'h00;
    end

    always_comb begin
        rdata_nx = rdata;
        for (int k = 0; k < MAX_DATA; k++) begin
            if (sh_done && (idx >= base_q) && (didx == IDX_W'(k)))
                rdata_nx[8*k +: 8] = sh_rx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op_q      <= '0;
            lsb_q     <= 1'b0;
            cpol_q    <= 1'b0;
            half_q    <= HALF_W'(1);
            gap_q     <= '0;
            gap_cnt   <= '0;
            offs_q    <= '0;
            alen_q    <= 3'd3;
            idx       <= '0;
            base_q    <= '0;
            last_q    <= '0;
            rdata     <= '0;
            cs_n      <= 1'b1;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cpol_q <= cfg_in.cpol;
                    if (req_valid && req_ready) begin
                        if (cfg_in.mode == CMD_USER) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= '0;
                        end else begin
                            op_q   <= cfg_in.opcode;
                            lsb_q  <= cfg_in.lsb_first;
                            half_q <= cfg_in.half;
                            gap_q  <= cfg_in.gap;
                            alen_q <= alen_in;
                            offs_q <= wide_addr_en ? req_offset : {8'h00, req_offset[23:0]};
                            base_q <= IDX_W'(1) + IDX_W'(alen_in) + IDX_W'(dum_in);
                            last_q <= IDX_W'(alen_in) + IDX_W'(dum_in) + IDX_W'(nb_in);
                            idx    <= '0;
                            rdata  <= '0;
                            cs_n   <= 1'b0;
                            state  <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: state <= ST_WAIT;
                ST_WAIT: begin
                    if (sh_done) begin
                        rdata <= rdata_nx;
                        if (idx == last_q) begin
                            cs_n      <= 1'b1;
                            rsp_valid <= 1'b1;
                            rsp_data  <= rdata_nx;
                            gap_cnt   <= gap_q - GAP_W'(1);
                            state     <= ST_GAP;
                        end else begin
                            idx   <= idx + IDX_W'(1);
                            state <= ST_LOAD;
                        end
                    end
                end
                default: begin
                    if (gap_cnt == '0) state <= ST_IDLE;
                    else               gap_cnt <= gap_cnt - GAP_W'(1);
                end
            endcase
        end
    end

    // deselect-time monitor
    logic [5:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (rst)                    hi_cnt <= 6'd63;
        else if (!cs_n)             hi_cnt <= '0;
        else if (hi_cnt != 6'd63)   hi_cnt <= hi_cnt + 6'd1;
    end

    AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> ($past(hi_cnt) >= 6'($past(gap_q)))); // R9
    AST_RSP_FRAMED: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> cs_n); // R9
    AST_BUSY_STALL: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> !req_ready); // R10
    AST_USER_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && ctrl_word[1:0] == 2'b11) |=>
        (cs_n && rsp_valid && rsp_data == '0)); // R11

endmodule

// File: rtl/spi_xip_reader.sv
module spi_xip_reader
    import spird_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] ctrl_word,
    input  logic        wide_addr_en,
    input  logic        req_valid,
    input  logic [31:0] req_offset,
    input  logic [1:0]  req_size,
    output logic        req_ready,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);

    logic              sh_start, sh_lsb, sh_cpol, sh_done;
    logic [7:0]        sh_tx, sh_rx;
    logic [HALF_W-1:0] sh_half;

    spird_seq i_seq (
        .clk          (clk),
        .rst          (rst),
        .ctrl_word    (ctrl_word),
        .wide_addr_en (wide_addr_en),
        .req_valid    (req_valid),
        .req_offset   (req_offset),
        .req_size     (req_size),
        .req_ready    (req_ready),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .cs_n         (spi_cs_n),
        .sh_start     (sh_start),
        .sh_tx        (sh_tx),
        .sh_lsb       (sh_lsb),
        .sh_half      (sh_half),
        .sh_cpol      (sh_cpol),
        .sh_done      (sh_done),
        .sh_rx        (sh_rx)
    );

    spird_shifter #(.TW(HALF_W)) i_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (sh_start),
        .tx_byte   (sh_tx),
        .lsb_first (sh_lsb),
        .half      (sh_half),
        .cpol      (sh_cpol),
        .miso      (spi_miso),
        .done      (sh_done),
        .rx_byte   (sh_rx),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi)
    );

    AST_CS_EDGE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> $stable(spi_sclk)); // R7

endmodule

// File: tb/test_spi_xip_reader.sv
module test_spi_xip_reader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ctrl_word = '0;
    logic        wide_addr_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_offset = '0;
    logic [1:0]  req_size = '0;
    logic        req_ready, rsp_valid, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
    logic [31:0] rsp_data;

    always #10 clk = ~clk;

    spi_xip_reader i_spi_xip_reader (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .wide_addr_en(wide_addr_en),
        .req_valid(req_valid), .req_offset(req_offset), .req_size(req_size),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    int         pos_cnt = 0;
    int         model_hdr_bits = 0;
    logic       model_lsb = 1'b0;
    logic [7:0] model_pat = 8'h00;
    logic [7:0] cap [0:23];
    logic       miso_q = 1'b0;
    assign spi_miso = miso_q;

    always @(negedge spi_cs_n) pos_cnt = 0;

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            if (pos_cnt / 8 < 24) begin
                if (model_lsb) cap[pos_cnt / 8][pos_cnt % 8] = spi_mosi;
                else           cap[pos_cnt / 8][7 - pos_cnt % 8] = spi_mosi;
            end
            pos_cnt++;
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n && pos_cnt >= model_hdr_bits) begin
            int d;
            logic [7:0] b;
            d = pos_cnt - model_hdr_bits;
            b = model_pat + 8'(d / 8) * 8'h3B;
            miso_q = model_lsb ? b[d % 8] : b[7 - d % 8];
        end
    end

    // ---------------- line monitor ----------------
    int cs_hi_run = 1000;
    int last_gap = 0;
    int hi_run = 0;
    int last_w = 0;
    int cs_falls = 0;
    logic cs_prev = 1'b1;

    always @(negedge clk) begin
        if (spi_cs_n) cs_hi_run++;
        else begin
            if (cs_hi_run > 0) last_gap = cs_hi_run;
            cs_hi_run = 0;
        end
        if (cs_prev && !spi_cs_n) cs_falls++;
        cs_prev = spi_cs_n;
        if (!spi_cs_n) begin
            if (spi_sclk) hi_run++;
            else if (hi_run > 0) begin last_w = hi_run; hi_run = 0; end
        end else hi_run = 0;
    end

    // ---------------- helpers ----------------
    int prev_need = 0;

    function automatic logic [31:0] mk(input int mode, input logic [7:0] op, input int dum,
                                       input bit lsb, input bit cpol, input int dv,
                                       input bit dv4, input int inact);
        logic [31:0] w;
        w = '0;
        w[1:0]   = 2'(mode);
        w[23:16] = op;
        w[14]    = 1'(dum >> 2);
        w[7:6]   = 2'(dum);
        w[5]     = lsb;
        w[4]     = cpol;
        w[11:8]  = 4'(dv);
        w[13]    = dv4;
        w[27:24] = 4'(inact);
        return w;
    endfunction

    function automatic logic [31:0] exp_data(input logic [7:0] pat, input int nb);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < nb; k++) r[8*k +: 8] = pat + 8'(k) * 8'h3B;
        return r;
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic int hdr_bits(input logic [31:0] cw, input bit a4);
        int dum;
        dum = (cw[1:0] == 2'd1) ? int'({cw[14], cw[7:6]}) : 0;
        return 8 * (1 + (a4 ? 4 : 3) + dum);
    endfunction

    task automatic check_header(input logic [31:0] cw, input bit a4, input logic [31:0] off, input string tag);
        int alen;
        logic [31:0] eo;
        alen = a4 ? 4 : 3;
        eo = a4 ? off : {8'h00, off[23:0]};
        check(cap[0] == cw[23:16], {tag, " R2 opcode"}, 64'(cap[0]), 64'(cw[23:16]));
        for (int i = 0; i < alen; i++) begin
            logic [7:0] e;
            e = 8'(eo >> (8 * (alen - 1 - i)));
            check(cap[1 + i] == e, {tag, " R3 address byte"}, 64'(cap[1 + i]), 64'(e));
        end
    endtask

    task automatic wait_rsp(output int waited);
        waited = 0;
        while (!rsp_valid && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic do_read(input logic [31:0] cw, input bit a4, input logic [31:0] off,
                           input logic [1:0] sz, input bit change_mid, input string tag);
        int waited, nb, half, need, falls0;
        nb   = nbytes(sz);
        half = (int'(cw[11:8]) + 1) * (cw[13] ? 4 : 1);
        need = 16 - int'(cw[27:24]);
        model_hdr_bits = hdr_bits(cw, a4);
        model_lsb = cw[5];
        model_pat = 8'($urandom);
        @(negedge clk);
        ctrl_word = cw; wide_addr_en = a4; req_offset = off; req_size = sz;
        @(negedge clk);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        falls0 = cs_falls;
        @(negedge clk);
        req_valid = 1'b0;
        if (change_mid) begin
            ctrl_word = ~cw;
            wide_addr_en = ~a4;
        end
        wait_rsp(waited);
        if (cw[1:0] == 2'd3) begin
            check(rsp_valid && waited == 0, {tag, " R11 immediate answer"}, 64'(waited), 64'd0);
            check(rsp_data == 32'h0, {tag, " R11 zero data"}, 64'(rsp_data), 64'd0);
            check(cs_falls == falls0, {tag, " R11 no select"}, 64'(cs_falls), 64'(falls0));
            return;
        end
        check(rsp_valid, {tag, " R9 response arrived"}, 64'(rsp_valid), 64'd1);
        check(spi_cs_n, {tag, " R9 select released with response"}, 64'(spi_cs_n), 64'd1);
        check(rsp_data == exp_data(model_pat, nb), {tag, cw[5] ? " R5 R6 data" : " R5 data"},
              64'(rsp_data), 64'(exp_data(model_pat, nb)));
        check(pos_cnt == model_hdr_bits + 8 * nb, {tag, " R4 total clock count"},
              64'(pos_cnt), 64'(model_hdr_bits + 8 * nb));
        check_header(cw, a4, off, tag);
        check(last_w == half, {tag, " R8 clock high width"}, 64'(last_w), 64'(half));
        if (prev_need > 0)
            check(last_gap >= prev_need, {tag, " R9 deselect time"}, 64'(last_gap), 64'(prev_need));
        prev_need = need;
        @(negedge clk);
        check(!rsp_valid, {tag, " R5 single pulse"}, 64'(rsp_valid), 64'd0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(spi_cs_n == 1'b1, "R1 cs idle", 64'(spi_cs_n), 64'd1);
        check(spi_sclk == 1'b0, "R1 sclk idle", 64'(spi_sclk), 64'd0);
        check(rsp_valid == 1'b0, "R1 no response", 64'(rsp_valid), 64'd0);
        check(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);

        // directed corner cases
        do_read(mk(0, 8'h03, 7, 0, 0, 0, 0, 15), 1'b0, 32'hAB123456, 2'd2, 1'b0, "R3 3-byte R4 normal ignores dummy");
        do_read(mk(1, 8'h0B, 7, 0, 0, 1, 0, 0),  1'b1, 32'hAB123456, 2'd1, 1'b0, "R3 4-byte R4 fast dummy 7");
        do_read(mk(2, 8'h02, 5, 0, 0, 0, 0, 8),  1'b0, 32'h00FEDCBA, 2'd0, 1'b0, "R4 write mode no dummy");
        do_read(mk(1, 8'h0B, 1, 1, 0, 0, 0, 4),  1'b1, 32'h12345678, 2'd3, 1'b0, "R6 lsb first");
        do_read(mk(0, 8'h13, 0, 0, 1, 1, 0, 2),  1'b1, 32'h89ABCDEF, 2'd2, 1'b0, "R7 mode 3");
        do_read(mk(0, 8'h03, 0, 0, 0, 0, 0, 0),  1'b0, 32'h00000000, 2'd0, 1'b0, "R9 long deselect");
        do_read(mk(0, 8'h03, 0, 0, 0, 15, 1, 6), 1'b0, 32'h00C0FFEE, 2'd0, 1'b0, "R8 max divider");
        do_read(mk(3, 8'h9F, 0, 0, 0, 0, 0, 0),  1'b0, 32'h00000010, 2'd2, 1'b0, "R11 user mode");
        do_read(mk(1, 8'h0C, 2, 1, 1, 2, 0, 10), 1'b1, 32'h5A5AA5A5, 2'd2, 1'b1, "R12 mid change");

        // R10: request held across a running transaction
        begin
            logic [31:0] cw;
            int waited;
            cw = mk(0, 8'h03, 0, 0, 0, 1, 0, 12);
            model_hdr_bits = hdr_bits(cw, 1'b0);
            model_lsb = 1'b0;
            model_pat = 8'h77;
            @(negedge clk);
            ctrl_word = cw; wide_addr_en = 1'b0; req_offset = 32'h00111111; req_size = 2'd1;
            @(negedge clk);
            req_valid = 1'b1;
            while (!req_ready) @(negedge clk);
            @(negedge clk);
            req_offset = 32'h00222222;
            repeat (5) @(negedge clk);
            check(!req_ready, "R10 ready low while busy", 64'(req_ready), 64'd0);
            wait_rsp(waited);
            check(rsp_data == exp_data(8'h77, 2), "R10 first data", 64'(rsp_data), 64'(exp_data(8'h77, 2)));
            check_header(cw, 1'b0, 32'h00111111, "R10 first");
            while (!req_ready) @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            wait_rsp(waited);
            check(rsp_valid && rsp_data == exp_data(8'h77, 2), "R10 held request served",
                  64'(rsp_data), 64'(exp_data(8'h77, 2)));
            check_header(cw, 1'b0, 32'h00222222, "R10 second");
            prev_need = 16 - 12;
        end

        // constrained random
        for (int i = 0; i < 40; i++) begin
            int mode, dv;
            bit dv4;
            mode = int'($urandom % 4);
            if (mode == 3 && ($urandom % 2) == 0) mode = 0;
            dv  = int'($urandom % 3);
            dv4 = (dv == 0) && ($urandom % 4 == 0);
            do_read(mk(mode, 8'($urandom), int'($urandom % 8), 1'($urandom), 1'($urandom),
                       dv, dv4, int'($urandom % 16)),
                    1'($urandom), $urandom, 2'($urandom), 1'($urandom % 5 == 0),
                    "random R2 R3 R4 R5 R6 R7 R8 R9 R12");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule